// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Level Alert

This block buffers the bytes that a serial bus engine receives until software collects them. The bus engine offers one byte per cycle on a push port. Software pulls bytes from a data port, and each pop strobe moves the oldest held byte into the output data register. The queue holds sixteen bytes, and the depth must be a power of two so that the pointers wrap naturally.

Software writes a zero-based threshold. The level alert is raised while the queue holds more bytes than the threshold value. Software can lower the threshold before the last, shorter part of a message, so that the tail also raises the alert. The block also reports fill status:

- an occupancy readback, which is the stored count minus one;
- a status byte with full and empty bits;
- a sticky overflow flag.

A synchronous soft clear returns everything to the reset state.

Top module: `rx_level_fifo`

## Requirements
- R1: After reset the block reports the following: status byte 0x40 (empty only), occupancy 0, threshold readback 0, interrupt flags 0x00, overflow 0 and popData 0.
- R2: Bytes leave in the order they arrived. A pop accepted at a clock edge presents its byte on popData from that edge onward, and popData holds that byte until the next accepted pop.
- R3: occupancy equals the stored count minus one while the queue is not empty, and reads 0 when it is empty.
- R4: statusByte bit 5 is 1 exactly when 16 bytes are held. Bit 6 is 1 exactly when none are held. All other status bits read 0.
- R5: A push while full with no pop in the same cycle is discarded: the held bytes and their order do not change. The push sets overflow, and overflow stays 1 until reset or soft clear.
- R6: A pop while empty changes nothing: popData keeps its last value and occupancy stays 0.
- R7: irqFlags bit 3 is 1 exactly when the stored count is greater than the threshold value T, that is, at T+1 bytes or more. It changes in the same cycle as the count. All other irqFlags bits read 0.
- R8: A threshold write (values 0 to 15) is shown on thrRdData from the next edge and is used for the R7 compare from then on.
- R9: When push and pop fall in the same cycle the outcome depends on the fill. If the queue is not empty, both are taken and the count is unchanged, including when it is full (no overflow). If it is empty, only the push is taken.
- R10: A softRst pulse returns the block to the R1 state at the next edge, which includes threshold 0 and overflow 0. It takes priority over any push, pop or threshold write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| softRst | input | 1 | Synchronous clear of the whole block |
| pushValid | input | 1 | Bus engine offers a received byte |
| pushData | input | 8 | Received byte |
| popReq | input | 1 | Data-port read strobe, removes one byte |
| popData | output | 8 | Last byte removed |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrData | input | 4 | Zero-based threshold value |
| thrRdData | output | 4 | Current threshold |
| occupancy | output | 4 | Stored count minus one (0 when empty) |
| statusByte | output | 8 | Bit 6 empty, bit 5 full |
| irqFlags | output | 8 | Bit 3 level reached |
| overflow | output | 1 | Sticky dropped-push flag |

## Verification
Push and pop can fall in the same cycle, and the outcome depends on the fill at that edge. When the queue is empty the pop must be ignored. When it is partly filled both are taken. When it is full the pop frees room for the push, so nothing is dropped. Directed sequences drive simultaneous push and pop at each of these three fills. A long random run then mixes them with threshold writes and soft clears. A queue-based model predicts every output, and the bench compares all outputs against it after each edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int STS_FULL_BIT  = 5;
  localparam int STS_EMPTY_BIT = 6;
  localparam int IRQ_LEVEL_BIT = 3;

  typedef struct packed {
    logic clear;
    logic wrEn;
    logic rdEn;
  } rxfStrobe_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       softRst,
  input  logic                       pushValid,
  input  logic                       popReq,
  input  logic                       thrWrEn,
  input  logic [$clog2(DEPTH)-1:0]   thrWrData,
  output rxfStrobe_t                 strb,
  output logic [$clog2(DEPTH)-1:0]   thrValue,
  output logic [$clog2(DEPTH)-1:0]   occMinusOne,
  output logic                       isFull,
  output logic                       isEmpty,
  output logic                       ovfFlag,
  output logic                       levelHit
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countLess;
  logic             rdOk;
  logic             wrOk;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);
  assign rdOk    = popReq && !isEmpty;
  assign wrOk    = pushValid && (!isFull || rdOk);

  always_comb begin
    strb.clear = softRst;
    strb.wrEn  = wrOk && !softRst;
    strb.rdEn  = rdOk && !softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (softRst) begin
      count <= '0;
    end else begin
      unique case ({strb.wrEn, strb.rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (softRst) begin
      ovfFlag <= 1'b0;
    end else if (pushValid && !wrOk) begin
      ovfFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrValue <= '0;
    end else if (softRst) begin
      thrValue <= '0;
    end else if (thrWrEn) begin
      thrValue <= thrWrData;
    end
  end

  assign countLess   = count - 1'b1;
  assign occMinusOne = isEmpty ? '0 : countLess[PTR_W-1:0];
  assign levelHit    = (count > CNT_W'(thrValue));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty));

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !softRst) |=> ovfFlag);

  a_r9_pair_holds_count: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && popReq && !isEmpty && !softRst) |=> (count == $past(count)));

  a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushValid && isEmpty && !softRst) |=> isEmpty);

  a_r7_no_level_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !levelHit);

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (isEmpty && thrValue == '0 && !ovfFlag));
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxfStrobe_t        strb,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      mem[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      popData <= '0;
    end else if (strb.clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      popData <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= wrPtr + 1'b1;
      if (strb.rdEn) begin
        rdPtr   <= rdPtr + 1'b1;
        popData <= mem[rdPtr];
      end
    end
  end

  a_r6_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdEn && !strb.clear) |=> $stable(popData));

  a_r10_clear_pointers: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (wrPtr == rdPtr && popData == '0));
endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  input  logic              thrWrEn,
  input  logic [PTR_W-1:0]  thrWrData,
  output logic [PTR_W-1:0]  thrRdData,
  output logic [PTR_W-1:0]  occupancy,
  output logic [7:0]        statusByte,
  output logic [7:0]        irqFlags,
  output logic              overflow
);
  rxfStrobe_t strb;
  logic       isFull;
  logic       isEmpty;
  logic       levelHit;

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .softRst     (softRst),
    .pushValid   (pushValid),
    .popReq      (popReq),
    .thrWrEn     (thrWrEn),
    .thrWrData   (thrWrData),
    .strb        (strb),
    .thrValue    (thrRdData),
    .occMinusOne (occupancy),
    .isFull      (isFull),
    .isEmpty     (isEmpty),
    .ovfFlag     (overflow),
    .levelHit    (levelHit)
  );

  rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pushData (pushData),
    .popData  (popData)
  );

  always_comb begin
    statusByte                = '0;
    statusByte[STS_FULL_BIT]  = isFull;
    statusByte[STS_EMPTY_BIT] = isEmpty;
    irqFlags                  = '0;
    irqFlags[IRQ_LEVEL_BIT]   = levelHit;
  end
endmodule

// File: tb/test_rx_level_fifo.sv
module test_rx_level_fifo;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic       pushValid = 1'b0;
  logic [7:0] pushData = 8'h00;
  logic       popReq = 1'b0;
  logic [7:0] popData;
  logic       thrWrEn = 1'b0;
  logic [3:0] thrWrData = 4'h0;
  logic [3:0] thrRdData;
  logic [3:0] occupancy;
  logic [7:0] statusByte;
  logic [7:0] irqFlags;
  logic       overflow;

  always #2 clk = ~clk;

  rx_level_fifo i_rx_level_fifo (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .popData(popData),
    .thrWrEn(thrWrEn), .thrWrData(thrWrData), .thrRdData(thrRdData),
    .occupancy(occupancy), .statusByte(statusByte),
    .irqFlags(irqFlags), .overflow(overflow)
  );

  logic [7:0] q[$];
  int         mThr = 0;
  bit         mOvf = 1'b0;
  logic [7:0] mLast = 8'h00;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;
  string      phase = "R1";

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic compareAll();
    int sz = q.size();
    logic [7:0] expSts = 8'h00;
    logic [7:0] expIrq = 8'h00;
    expSts[6] = (sz == 0);
    expSts[5] = (sz == 16);
    expIrq[3] = (sz > mThr);
    check("R2 popData", popData, mLast);
    check("R3 occupancy", occupancy, (sz == 0) ? 0 : sz - 1);
    check("R4 statusByte", statusByte, expSts);
    check("R5 overflow", overflow, mOvf);
    check("R7 irqFlags", irqFlags, expIrq);
    check("R8 thrRdData", thrRdData, mThr);
  endtask

  task automatic modelEdge(bit ps, logic [7:0] d, bit pp, bit tw, int td, bit sr);
    bit popOk, pushOk;
    if (sr) begin
      q.delete(); mThr = 0; mOvf = 1'b0; mLast = 8'h00;
    end else begin
      popOk  = pp && (q.size() != 0);
      pushOk = ps && ((q.size() != 16) || popOk);
      if (popOk) mLast = q.pop_front();
      if (pushOk) q.push_back(d);
      if (ps && !pushOk) mOvf = 1'b1;
      if (tw) mThr = td;
    end
  endtask

  task automatic step(bit ps, logic [7:0] d, bit pp, bit tw, int td, bit sr);
    @(negedge clk);
    compareAll();
    pushValid = ps; pushData = d; popReq = pp;
    thrWrEn = tw; thrWrData = 4'(td); softRst = sr;
    @(posedge clk);
    modelEdge(ps, d, pp, tw, td, sr);
  endtask

  task automatic idle(); step(0, 8'h00, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    phase = "R1 reset";
    idle();

    phase = "R2 R3 R7 order";
    for (int i = 0; i < 5; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 8'h00, 1, 0, 0, 0);

    phase = "R8 R7 threshold";
    step(0, 8'h00, 0, 1, 3, 0);
    for (int i = 0; i < 5; i++) step(1, 8'(8'h30 + i), 0, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0, 0);
    step(0, 8'h00, 0, 1, 1, 0);
    step(0, 8'h00, 0, 1, 15, 0);
    for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 0, 0, 0);

    phase = "R4 R5 full overflow";
    step(0, 8'h00, 0, 1, 0, 0);
    for (int i = 0; i < 16; i++) step(1, 8'(8'h80 + i), 0, 0, 0, 0);
    step(1, 8'hEE, 0, 0, 0, 0);
    step(1, 8'hEF, 0, 0, 0, 0);
    idle();

    phase = "R9 full push+pop";
    step(1, 8'h55, 1, 0, 0, 0);
    idle();
    for (int i = 0; i < 17; i++) step(0, 8'h00, 1, 0, 0, 0);

    phase = "R6 empty pop";
    for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 0, 0, 0);

    phase = "R9 empty and mid push+pop";
    step(1, 8'hA1, 1, 0, 0, 0);
    step(1, 8'hA2, 0, 0, 0, 0);
    step(1, 8'hA3, 1, 0, 0, 0);
    step(1, 8'hA4, 1, 0, 0, 0);

    phase = "R10 soft clear";
    step(0, 8'h00, 0, 1, 7, 0);
    for (int i = 0; i < 16; i++) step(1, 8'(i), 0, 0, 0, 0);
    step(1, 8'hFF, 0, 0, 0, 0);
    step(1, 8'h77, 1, 1, 9, 1);
    idle();

    phase = "R9 random mix";
    for (int i = 0; i < 4000; i++) begin
      int fill = (i / 500) % 2;
      bit ps = ($urandom_range(0, 99) < (fill ? 70 : 40));
      bit pp = ($urandom_range(0, 99) < (fill ? 40 : 70));
      bit tw = ($urandom_range(0, 99) < 4);
      bit sr = ($urandom_range(0, 999) < 3);
      step(ps, 8'($urandom), pp, tw, $urandom_range(0, 15), sr);
    end
    idle();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule